// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the memory-to-stream half of one DMA channel. Given the address of a data descriptor, it fetches the four descriptor words through a single-word memory master port. It then reads the byte range that the descriptor names and sends it out, one byte per handshake, on a valid/ready stream. The stream carries a last marker and a 16-bit metadata sideband that is flagged on the first byte of each packet.

When a descriptor's range has been sent, the walker writes its flags word back to memory and pulses an interrupt if the descriptor asks for one. If the descriptor is not the end of the list, the walker moves to the next one. If it is the end of the list, the walker performs a read-modify-write on the channel's context descriptor to set its disable bit, then raises a sticky end-of-list flag and goes idle.

Long buffers are split into bursts. After each burst the descriptor is fetched again, so software can change it while a transfer is under way.

Top module: `txw_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `tx_valid_o`, `mem_req_o`, `irq_o` and `eol_o` are all 0.
- R2: A start pulse while idle makes the walker read the words at ptr, ptr+4, ptr+8 and ptr+12, in that order. These words are, in turn, the next pointer, the buffer start, the flags and the buffer end (exclusive). In the flags word, bit 0 is end of list, bit 3 is end of packet, bit 4 is interrupt request, and bits 31:16 are the metadata.
- R3: The bytes at addresses [start, end) are sent in ascending address order, and `buf_ptr_o` shows the address of the byte being offered. The byte at address a is taken from bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word read at a with its two low bits cleared. The walker never requests memory while it offers a byte. An empty range sends no bytes.
- R4: `tx_last_o` is 1 only on the final byte of a range whose descriptor has flags bit 3 set.
- R5: `tx_first_o` is 1 on the first byte after a start, and on the first byte after a descriptor with flags bit 3 completes. `tx_meta_o` equals flags bits 31:16 of the descriptor that owns the byte.
- R6: After every BURST_BYTES bytes of one descriptor, if bytes remain, the four descriptor words are read again before the next data word. The buffer position is kept across this re-read.
- R7: When a range is finished, the flags word is written back to ptr+8.
- R8: `irq_o` pulses for one cycle, in the cycle after the flags write-back is granted, exactly when flags bit 4 is set.
- R9: When flags bit 0 is clear, the next descriptor is fetched from the next pointer right after the write-back.
- R10: When flags bit 0 is set, the walker reads the word at ctx+4 and writes it back with bit 15 set. It then raises `eol_o` and drops `busy_o`.
- R11: While `eol_o` is 1, a start pulse causes no memory access and no stream output, and `eol_o` stays 1 until reset.
- R12: A byte offered and not accepted keeps its valid, data and last values. A memory request that is not granted keeps its request, address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| desc_ptr_i | input | 32 | First data descriptor address, taken at start |
| ctx_ptr_i | input | 32 | Context descriptor address, taken at start |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | End of packet |
| tx_first_o | output | 1 | First byte of a packet; metadata applies |
| tx_meta_o | output | 16 | Metadata sideband |
| irq_o | output | 1 | Descriptor-done interrupt pulse |
| eol_o | output | 1 | Sticky end-of-list flag |
| busy_o | output | 1 | Walker active |
| buf_ptr_o | output | 32 | Address of the current byte |
| cur_desc_o | output | 32 | Address of the current descriptor |

## Verification
The assertions assume that the memory side grants only while a request is up, and that it returns exactly one `mem_rvalid_i` for each granted read, after the grant and before the next request. The stimulus follows this rule. The bench memory returns read data in the cycle after each read grant. It withholds grant in one cycle out of three and withholds stream ready in one cycle out of four, so every hold path is exercised. The descriptors keep buffer starts word-aligned and leave the chain in memory unchanged while it is walked, so the burst re-read returns the same fields.

// File: rtl/txw_pkg.sv
package txw_pkg;
    localparam int TXW_AW = 32;
    localparam int TXW_DW = 32;
    localparam int TXW_BW = 8;
    localparam int TXW_LANES = TXW_DW / TXW_BW;

    // flag positions a neighbour (software, descriptor writer) decodes
    localparam int FLAG_EOL     = 0;
    localparam int FLAG_PKT_END = 3;
    localparam int FLAG_IRQ     = 4;
    localparam int CTX_DISABLE  = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_SEND,
        ST_WBACK,
        ST_CTX_RD,
        ST_CTX_WR
    } txw_state_e;

    typedef struct packed {
        txw_state_e          st;
        logic                rd_wait;
        logic [1:0]          widx;
        logic                reload;
        logic                pkt_open;
        logic                eol;
        logic                irq;
        logic [TXW_AW-1:0]   dptr;
        logic [TXW_AW-1:0]   cptr;
        logic [TXW_AW-1:0]   nxt;
        logic [TXW_AW-1:0]   bptr;
        logic [TXW_DW-1:0]   flags;
        logic [TXW_AW-1:0]   after;
        logic [TXW_DW-1:0]   word;
        logic [TXW_DW-1:0]   cflags;
    } txw_regs_t;
endpackage

// File: rtl/txw_burst_meter.sv
module txw_burst_meter #(
    parameter int BURST_BYTES = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic near_full_o
);
    localparam int CW = $clog2(BURST_BYTES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign near_full_o = (cnt_q == CW'(BURST_BYTES - 1));

    // the burst window is closed by a descriptor re-read before it overruns
    assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BURST_BYTES));
endmodule

// File: rtl/txw_byte_pick.sv
module txw_byte_pick
    import txw_pkg::*;
(
    input  logic [TXW_DW-1:0]            word_i,
    input  logic [$clog2(TXW_LANES)-1:0] lane_i,
    output logic [TXW_BW-1:0]            byte_o
);
    logic [TXW_BW-1:0] lanes [TXW_LANES];

    for (genvar i = 0; i < TXW_LANES; i++) begin : g_lane
        assign lanes[i] = word_i[i*TXW_BW +: TXW_BW];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txw_walker.sv
module txw_walker
    import txw_pkg::*;
#(
    parameter int BURST_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       desc_ptr_i,
    input  logic [31:0]       ctx_ptr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    output logic              tx_first_o,
    output logic [15:0]       tx_meta_o,
    output logic              irq_o,
    output logic              eol_o,
    output logic              busy_o,
    output logic [31:0]       buf_ptr_o,
    output logic [31:0]       cur_desc_o
);
    localparam int LW = $clog2(TXW_LANES);

    txw_regs_t s_d, s_q;

    logic              meter_clr, meter_inc, meter_near_full;
    logic [TXW_AW-1:0] bptr_inc;
    logic              at_end;
    logic [TXW_BW-1:0] cur_byte;

    assign bptr_inc = s_q.bptr + TXW_AW'(1);
    assign at_end   = (bptr_inc == s_q.after);

    txw_burst_meter #(.BURST_BYTES(BURST_BYTES)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (meter_clr),
        .inc_i       (meter_inc),
        .near_full_o (meter_near_full)
    );

    txw_byte_pick u_pick (
        .word_i (s_q.word),
        .lane_i (s_q.bptr[LW-1:0]),
        .byte_o (cur_byte)
    );

    // memory port, driven from state only
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (s_q.st)
            ST_FETCH: begin
                mem_req_o  = !s_q.rd_wait;
                mem_addr_o = s_q.dptr + {28'd0, s_q.widx, 2'b00};
            end
            ST_READ: begin
                mem_req_o  = !s_q.rd_wait;
                mem_addr_o = {s_q.bptr[TXW_AW-1:2], 2'b00};
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = s_q.dptr + TXW_AW'(8);
                mem_wdata_o = s_q.flags;
            end
            ST_CTX_RD: begin
                mem_req_o  = !s_q.rd_wait;
                mem_addr_o = s_q.cptr + TXW_AW'(4);
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = s_q.cptr + TXW_AW'(4);
                mem_wdata_o = s_q.cflags | (TXW_DW'(1) << CTX_DISABLE);
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        meter_clr = 1'b0;
        meter_inc = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i && !s_q.eol) begin
                    s_d.dptr     = desc_ptr_i;
                    s_d.cptr     = ctx_ptr_i;
                    s_d.widx     = 2'd0;
                    s_d.reload   = 1'b0;
                    s_d.pkt_open = 1'b1;
                    s_d.st       = ST_FETCH;
                    meter_clr    = 1'b1;
                end
            end
            ST_FETCH: begin
                if (!s_q.rd_wait) begin
                    if (mem_gnt_i) s_d.rd_wait = 1'b1;
                end else if (mem_rvalid_i) begin
                    s_d.rd_wait = 1'b0;
                    s_d.widx    = s_q.widx + 2'd1;
                    unique case (s_q.widx)
                        2'd0: s_d.nxt = mem_rdata_i;
                        2'd1: if (!s_q.reload) s_d.bptr = mem_rdata_i;
                        2'd2: s_d.flags = mem_rdata_i;
                        default: begin
                            s_d.after  = mem_rdata_i;
                            s_d.reload = 1'b0;
                            meter_clr  = 1'b1;
                            s_d.st     = (s_q.bptr == mem_rdata_i) ? ST_WBACK : ST_READ;
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (!s_q.rd_wait) begin
                    if (mem_gnt_i) s_d.rd_wait = 1'b1;
                end else if (mem_rvalid_i) begin
                    s_d.rd_wait = 1'b0;
                    s_d.word    = mem_rdata_i;
                    s_d.st      = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready_i) begin
                    meter_inc    = 1'b1;
                    s_d.bptr     = bptr_inc;
                    s_d.pkt_open = 1'b0;
                    if (at_end) begin
                        s_d.st = ST_WBACK;
                    end else if (meter_near_full) begin
                        s_d.reload = 1'b1;
                        s_d.widx   = 2'd0;
                        s_d.st     = ST_FETCH;
                    end else if (s_q.bptr[LW-1:0] == LW'(TXW_LANES - 1)) begin
                        s_d.st = ST_READ;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_gnt_i) begin
                    s_d.irq = s_q.flags[FLAG_IRQ];
                    if (s_q.flags[FLAG_PKT_END]) s_d.pkt_open = 1'b1;
                    if (s_q.flags[FLAG_EOL]) begin
                        s_d.st = ST_CTX_RD;
                    end else begin
                        s_d.dptr = s_q.nxt;
                        s_d.widx = 2'd0;
                        s_d.st   = ST_FETCH;
                    end
                end
            end
            ST_CTX_RD: begin
                if (!s_q.rd_wait) begin
                    if (mem_gnt_i) s_d.rd_wait = 1'b1;
                end else if (mem_rvalid_i) begin
                    s_d.rd_wait = 1'b0;
                    s_d.cflags  = mem_rdata_i;
                    s_d.st      = ST_CTX_WR;
                end
            end
            ST_CTX_WR: begin
                if (mem_gnt_i) begin
                    s_d.eol = 1'b1;
                    s_d.st  = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = (s_q.st == ST_SEND);
    assign tx_data_o  = cur_byte;
    assign tx_last_o  = tx_valid_o && s_q.flags[FLAG_PKT_END] && at_end;
    assign tx_first_o = tx_valid_o && s_q.pkt_open;
    assign tx_meta_o  = s_q.flags[31:16];
    assign irq_o      = s_q.irq;
    assign eol_o      = s_q.eol;
    assign busy_o     = (s_q.st != ST_IDLE);
    assign buf_ptr_o  = s_q.bptr;
    assign cur_desc_o = s_q.dptr;

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid_o, mem_req_o}));

    assert_irq_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));

    assert_eol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |=> eol_o);

    assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);
endmodule

// File: tb/txw_walker_tb.sv
module txw_walker_tb;
    localparam int BURST = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [31:0] desc_ptr_i = '0, ctx_ptr_i = '0;
    logic mem_req_o, mem_we_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
    logic tx_valid_o, tx_ready_i = 1'b0, tx_last_o, tx_first_o;
    logic [7:0] tx_data_o;
    logic [15:0] tx_meta_o;
    logic irq_o, eol_o, busy_o;
    logic [31:0] buf_ptr_o, cur_desc_o;

    always #4 clk = ~clk;

    txw_walker #(.BURST_BYTES(BURST)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .desc_ptr_i(desc_ptr_i), .ctx_ptr_i(ctx_ptr_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .tx_data_o(tx_data_o), .tx_last_o(tx_last_o), .tx_first_o(tx_first_o),
        .tx_meta_o(tx_meta_o), .irq_o(irq_o), .eol_o(eol_o), .busy_o(busy_o),
        .buf_ptr_o(buf_ptr_o), .cur_desc_o(cur_desc_o)
    );

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic        irq;
        int          kind; // 0 fetch,1 reload,2 data,3 wb,4 ctx rd,5 ctx wr,6 next fetch
    } acc_t;

    typedef struct {
        logic [7:0]  data;
        logic        last;
        logic        first;
        logic [15:0] meta;
        logic [31:0] addr;
    } byte_t;

    logic [31:0] mem [int unsigned];
    acc_t  acc_q [$];
    byte_t byte_q [$];

    int checks = 0, failures = 0, cyc = 0;
    logic exp_irq = 1'b0;
    logic rd_pend = 1'b0;
    logic [31:0] rd_addr = '0;
    logic held_tx = 1'b0, held_req = 1'b0;
    logic [7:0] held_data = '0;
    logic [31:0] held_addr = '0;
    logic done = 1'b0;

    function automatic string kind_req(int k);
        case (k)
            0: return "R2";
            1: return "R6";
            2: return "R3";
            3: return "R7";
            4, 5: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic push_acc(input logic [31:0] a, input logic we, input logic [31:0] wd, input logic irq, input int kind);
        acc_t e;
        e.addr = a; e.we = we; e.wdata = wd; e.irq = irq; e.kind = kind;
        acc_q.push_back(e);
    endtask

    // behavioural reference: walks the chain in the bench memory
    task automatic expect_chain(input logic [31:0] d0, input logic [31:0] c);
        logic [31:0] d, nx, bf, fl, af, pos, w;
        int cnt;
        bit need, pkt, first_desc;
        byte_t b;
        d = d0; pkt = 1; first_desc = 1;
        forever begin
            for (int i = 0; i < 4; i++) push_acc(d + 32'(4*i), 1'b0, '0, 1'b0, first_desc ? 0 : 6);
            first_desc = 0;
            nx = mem[d]; bf = mem[d+4]; fl = mem[d+8]; af = mem[d+12];
            pos = bf; cnt = 0; need = 1;
            while (pos != af) begin
                if (need) begin
                    push_acc({pos[31:2], 2'b00}, 1'b0, '0, 1'b0, 2);
                    need = 0;
                end
                w = mem[{pos[31:2], 2'b00}];
                b.data  = 8'(w >> (8 * pos[1:0]));
                b.last  = fl[3] && (pos + 1 == af);
                b.first = pkt;
                b.meta  = fl[31:16];
                b.addr  = pos;
                byte_q.push_back(b);
                pkt = 0;
                pos++; cnt++;
                if (pos == af) break;
                if (cnt == BURST) begin
                    for (int i = 0; i < 4; i++) push_acc(d + 32'(4*i), 1'b0, '0, 1'b0, 1);
                    cnt = 0; need = 1;
                end else if (pos[1:0] == 2'b00) begin
                    need = 1;
                end
            end
            push_acc(d + 8, 1'b1, fl, fl[4], 3);
            if (fl[3]) pkt = 1;
            if (fl[0]) begin
                push_acc(c + 4, 1'b0, '0, 1'b0, 4);
                push_acc(c + 4, 1'b1, mem[c+4] | 32'h0000_8000, 1'b0, 5);
                break;
            end
            d = nx;
        end
    endtask

    // bench memory, stream sink and every-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            check(1'b0, "watchdog", 32'(cyc), 32'd20000);
            done = 1'b1;
        end
        if (!rst_n) begin
            mem_rvalid_i = 1'b0; rd_pend = 1'b0; mem_gnt_i = 1'b0;
            exp_irq = 1'b0; held_tx = 1'b0; held_req = 1'b0;
        end else begin
            mem_rvalid_i = rd_pend;
            mem_rdata_i  = rd_pend ? mem[rd_addr] : 32'h0;
            rd_pend      = 1'b0;
            mem_gnt_i    = mem_req_o && (cyc % 3 != 1);
            tx_ready_i   = (cyc % 4 != 2);
            #1;
            check(irq_o == exp_irq, "R8", {31'd0, irq_o}, {31'd0, exp_irq});
            exp_irq = 1'b0;
            if (held_tx) begin
                check(tx_valid_o && tx_data_o == held_data, "R12", {24'd0, tx_data_o}, {24'd0, held_data});
            end
            if (held_req) begin
                check(mem_req_o && mem_addr_o == held_addr, "R12", mem_addr_o, held_addr);
            end
            held_tx = tx_valid_o && !tx_ready_i;
            held_data = tx_data_o;
            held_req = mem_req_o && !mem_gnt_i;
            held_addr = mem_addr_o;
            if (mem_req_o && mem_gnt_i) begin
                if (acc_q.size() == 0) begin
                    check(1'b0, "R11", mem_addr_o, 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    e = acc_q.pop_front();
                    check(mem_addr_o == e.addr && mem_we_o == e.we, kind_req(e.kind), mem_addr_o, e.addr);
                    if (e.we) begin
                        check(mem_wdata_o == e.wdata, kind_req(e.kind), mem_wdata_o, e.wdata);
                        mem[mem_addr_o] = mem_wdata_o;
                        if (e.kind == 3) exp_irq = e.irq;
                    end else begin
                        rd_pend = 1'b1;
                        rd_addr = mem_addr_o;
                    end
                end
            end
            if (tx_valid_o && tx_ready_i) begin
                if (byte_q.size() == 0) begin
                    check(1'b0, "R11", {24'd0, tx_data_o}, 32'hFFFF_FFFF);
                end else begin
                    byte_t b;
                    b = byte_q.pop_front();
                    check(tx_data_o == b.data, "R3", {24'd0, tx_data_o}, {24'd0, b.data});
                    check(buf_ptr_o == b.addr, "R3", buf_ptr_o, b.addr);
                    check(tx_last_o == b.last, "R4", {31'd0, tx_last_o}, {31'd0, b.last});
                    check(tx_first_o == b.first, "R5", {31'd0, tx_first_o}, {31'd0, b.first});
                    check(tx_meta_o == b.meta, "R5", {16'd0, tx_meta_o}, {16'd0, b.meta});
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!busy_o && !tx_valid_o && !mem_req_o && !irq_o && !eol_o, "R1",
              {27'd0, busy_o, tx_valid_o, mem_req_o, irq_o, eol_o}, 32'd0);
    endtask

    task automatic run_chain(input logic [31:0] d, input logic [31:0] c);
        expect_chain(d, c);
        @(negedge clk);
        start_i = 1'b1; desc_ptr_i = d; ctx_ptr_i = c;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #2;
            if (acc_q.size() == 0 && byte_q.size() == 0 && !busy_o) break;
        end
        check(acc_q.size() == 0 && byte_q.size() == 0, "R9", 32'(acc_q.size() + byte_q.size()), 32'd0);
        check(eol_o && !busy_o, "R10", {30'd0, eol_o, busy_o}, 32'd2);
    endtask

    initial begin
        logic [31:0] held_ptr;
        for (int a = 32'h100; a < 32'h140; a += 4)
            mem[a] = {8'(a + 3) ^ 8'h5A, 8'(a + 2) ^ 8'h3C, 8'(a + 1), 8'(a) ^ 8'hC3};
        // run A: one descriptor, 12 bytes, crosses one burst boundary
        mem[32'h40] = 32'h0; mem[32'h44] = 32'h100; mem[32'h48] = 32'hA5C3_0019; mem[32'h4C] = 32'h10C;
        mem[32'h24] = 32'h0000_1234;
        // run B: four descriptors incl. an empty one
        mem[32'h80] = 32'h90; mem[32'h84] = 32'h110; mem[32'h88] = 32'h1111_0018; mem[32'h8C] = 32'h113;
        mem[32'h90] = 32'hA0; mem[32'h94] = 32'h120; mem[32'h98] = 32'h2222_0000; mem[32'h9C] = 32'h12A;
        mem[32'hA0] = 32'hB0; mem[32'hA4] = 32'h130; mem[32'hA8] = 32'h3333_0010; mem[32'hAC] = 32'h130;
        mem[32'hB0] = 32'h0;  mem[32'hB4] = 32'h134; mem[32'hB8] = 32'h4444_0009; mem[32'hBC] = 32'h136;
        mem[32'h34] = 32'h00F0_0001;

        do_reset();
        run_chain(32'h40, 32'h20);
        do_reset();
        run_chain(32'h80, 32'h30);

        // start while at end of list: nothing may happen
        held_ptr = buf_ptr_o;
        @(negedge clk);
        start_i = 1'b1; desc_ptr_i = 32'h40; ctx_ptr_i = 32'h20;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        #2;
        check(!busy_o && eol_o && buf_ptr_o == held_ptr, "R11", buf_ptr_o, held_ptr);
        check(mem[32'h34] == 32'h00F0_8001, "R10", mem[32'h34], 32'h00F0_8001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        #20;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule